// File: doc/BRIEF.md
# Ethernet test frame generator

This block produces a continuous stream of identical Ethernet test frames on a byte-wide transmit interface. It drives a data byte, a transmit-enable strobe and a transmit-error strobe, and it is used during link and PHY bring-up to put known traffic on the wire. Each frame is preamble, start delimiter, destination address, source address, length field, a repeating payload and a CRC-32 check sequence. An idle gap with the enable strobe low follows each frame.

A small control set selects the frame contents. Two 4-bit selectors choose one of sixteen addresses for each address field. One flag holds the error strobe high for whole frames, and another flag sends a deliberately wrong check sequence. A 16-bit pattern fills the payload. These controls are sampled only when the generator leaves its idle state. While the run bit stays high, frames follow each other with the minimum gap. When the run bit is cleared, the frame in progress is completed before the generator stops.

Top module: `test_frame_gen`

## Requirements
- R1: After a synchronous active-low reset, `txd_o` is 0x00, `tx_en_o` and `tx_er_o` are low, `frame_cnt_o` is zero, and the held configuration, including the payload pattern, is all zeros.
- R2: A frame holds `tx_en_o` high for 72 consecutive cycles. The bytes are seven 0x55, then one 0xD5, then 6 destination bytes, then 6 source bytes, then the length field 0x00 then 0x2E, then 46 payload bytes, then 4 check bytes.
- R3: The first byte of each address is 0xF in the upper nibble, with the 4-bit selector in the lower nibble. The next five bytes of that address are 0xFF. The destination address uses `dst_sel_i` and the source address uses `src_sel_i`.
- R4: When the held TX_ER enable is 1, `tx_er_o` is high on every cycle of the frame. When it is 0, `tx_er_o` stays low. `tx_er_o` is never high while `tx_en_o` is low.
- R5: The payload bytes alternate between `pattern_i[15:8]` and `pattern_i[7:0]`, starting with the high byte.
- R6: The check bytes are the reflected CRC-32 (polynomial 0xEDB88320, start value 0xFFFFFFFF, final inversion) of the bytes from the destination address through the payload. They are sent least-significant byte first. When the held bad-FCS flag is 1, the bitwise complement of that value is sent instead.
- R7: The selectors, the two flags and the pattern are captured only on the clock edge where the generator leaves idle with `run_i` high. Changes made while frames are running are ignored. This includes a low pulse on `run_i` that ends before the current frame's gap is over.
- R8: While `run_i` stays high, exactly 12 cycles with `tx_en_o` low separate consecutive frames. Every gap between frames is at least 12 cycles.
- R9: `run_i` is sampled only at the last gap cycle. A frame that has started always runs to completion, and if `run_i` is low at that point, no further frame starts.
- R10: `frame_cnt_o` increases by exactly one on the cycle where `tx_en_o` falls after a complete frame, and it changes at no other time.
- R11: While `tx_en_o` is low, `txd_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Run request; high to generate frames |
| dst_sel_i | input | 4 | Low nibble of the first destination address byte |
| src_sel_i | input | 4 | Low nibble of the first source address byte |
| txer_en_i | input | 1 | Hold the error strobe high for whole frames |
| bad_fcs_i | input | 1 | Send the complemented check sequence |
| pattern_i | input | 16 | Payload word, high byte sent first |
| txd_o | output | 8 | Transmit data byte |
| tx_en_o | output | 1 | Transmit enable |
| tx_er_o | output | 1 | Transmit error |
| frame_cnt_o | output | CNT_W (16) | Count of completed frames |

## Verification
The assertions check every cycle the properties that hold for any configuration:
- frame length and the leading preamble byte;
- the minimum idle gap;
- a quiet bus while idle;
- a steady error strobe within a frame;
- a frozen held configuration while a frame is on the wire;
- single steps of the frame count, aligned with frame ends.

Only the bench scenarios can show the values that depend on the configuration: the address bytes, the payload alternation and the check sequence. They are also needed for the proof that mid-run control changes and a brief run-bit drop are ignored, and that a fresh start picks up the new settings.

// File: rtl/efg_pkg.sv
// Shared types and helpers for the Ethernet test frame generator.
// Assumes byte-wide transmit data and the reflected CRC-32 bit order.
package efg_pkg;

    localparam int SEL_W = 4;
    localparam int PAT_W = 16;

    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    // Frame section currently on the wire
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PRE,
        PH_SFD,
        PH_DST,
        PH_SRC,
        PH_LEN,
        PH_PAY,
        PH_FCS,
        PH_GAP
    } phase_t;

    // Configuration held for the duration of a run
    typedef struct packed {
        logic [SEL_W-1:0] dst_sel;
        logic [SEL_W-1:0] src_sel;
        logic             txer_en;
        logic             bad_fcs;
        logic [PAT_W-1:0] pattern;
    } gen_cfg_t;

    // One byte through the reflected CRC-32, eight bit steps unrolled
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/efg_cfg_hold.sv
// Holds the run configuration.
// Loads only on the start pulse from the sequencer, so the settings cannot
// change while a run is active. Resets to all zeros.
module efg_cfg_hold
    import efg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture_i,
    input  gen_cfg_t cfg_i,
    output gen_cfg_t cfg_o
);

    // Capture the configuration on a fresh start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (capture_i) begin
            cfg_o <= cfg_i;
        end
    end

endmodule

// File: rtl/efg_crc_acc.sv
// Running CRC-32 register.
// Seeded while the start delimiter is sent, then advanced by one byte per
// data cycle. Holds its value through the check-byte phase.
module efg_crc_acc
    import efg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        upd_i,
    input  logic [7:0]  byte_i,
    output logic [31:0] crc_o
);

    // Seed, advance or hold the running CRC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_o <= CRC_SEED;
        end else if (init_i) begin
            crc_o <= CRC_SEED;
        end else if (upd_i) begin
            crc_o <= crc32_step(crc_o, byte_i);
        end
    end

endmodule

// File: rtl/efg_sequencer.sv
// Frame sequencer.
// Walks the frame sections with a byte index and counts completed frames.
// Assumes every section is at least one byte long and the payload is
// at least 4 bytes.
module efg_sequencer
    import efg_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int PAY_LEN = 46,
    parameter int GAP_LEN = 12,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output phase_t           phase_o,
    output logic [7:0]       idx_o,
    output logic             start_o,
    output logic [CNT_W-1:0] frame_cnt_o
);

    localparam int MAX_LEN = (PAY_LEN > GAP_LEN) ? ((PAY_LEN > PRE_LEN) ? PAY_LEN : PRE_LEN)
                                                 : ((GAP_LEN > PRE_LEN) ? GAP_LEN : PRE_LEN);
    localparam int IDX_W   = $clog2(MAX_LEN + 1);

    phase_t           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d, last_idx;
    logic             frame_done;

    // Last byte index of the current section
    always_comb begin
        case (phase_q)
            PH_PRE:         last_idx = IDX_W'(PRE_LEN - 1);
            PH_DST, PH_SRC: last_idx = IDX_W'(5);
            PH_LEN:         last_idx = IDX_W'(1);
            PH_PAY:         last_idx = IDX_W'(PAY_LEN - 1);
            PH_FCS:         last_idx = IDX_W'(3);
            PH_GAP:         last_idx = IDX_W'(GAP_LEN - 1);
            default:        last_idx = '0;
        endcase
    end

    // Next section and index
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        if (phase_q == PH_IDLE) begin
            if (run_i) begin
                phase_d = PH_PRE;
                idx_d   = '0;
            end
        end else if (idx_q == last_idx) begin
            idx_d = '0;
            case (phase_q)
                PH_PRE:  phase_d = PH_SFD;
                PH_SFD:  phase_d = PH_DST;
                PH_DST:  phase_d = PH_SRC;
                PH_SRC:  phase_d = PH_LEN;
                PH_LEN:  phase_d = PH_PAY;
                PH_PAY:  phase_d = PH_FCS;
                PH_FCS:  phase_d = PH_GAP;
                PH_GAP:  phase_d = run_i ? PH_PRE : PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end else begin
            idx_d = idx_q + 1'b1;
        end
    end

    assign start_o    = (phase_q == PH_IDLE) && run_i;
    assign frame_done = (phase_q == PH_FCS) && (idx_q == last_idx);

    // Section state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    // Completed-frame counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt_o <= '0;
        end else if (frame_done) begin
            frame_cnt_o <= frame_cnt_o + 1'b1;
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = 8'(idx_q);

endmodule

// File: rtl/efg_byte_mux.sv
// Output byte selection.
// Decodes the section and index into the transmit byte and the strobes,
// and tells the CRC register when to seed and when to advance. All inputs
// come from flops.
module efg_byte_mux
    import efg_pkg::*;
#(
    parameter int PAY_LEN = 46
) (
    input  phase_t      phase_i,
    input  logic [7:0]  idx_i,
    input  gen_cfg_t    cfg_i,
    input  logic [31:0] crc_i,
    output logic [7:0]  txd_o,
    output logic        tx_en_o,
    output logic        tx_er_o,
    output logic        crc_init_o,
    output logic        crc_upd_o
);

    localparam logic [15:0] LEN_FIELD = 16'(PAY_LEN);

    logic [31:0] fcs_word;

    assign fcs_word = cfg_i.bad_fcs ? crc_i : ~crc_i;

    // Byte and strobe decode per section
    always_comb begin
        txd_o     = 8'h00;
        tx_en_o   = 1'b1;
        crc_upd_o = 1'b0;
        case (phase_i)
            PH_PRE: txd_o = PRE_BYTE;
            PH_SFD: txd_o = SFD_BYTE;
            PH_DST: begin
                crc_upd_o = 1'b1;
                txd_o     = (idx_i == 8'd0) ? {4'hF, cfg_i.dst_sel} : 8'hFF;
            end
            PH_SRC: begin
                crc_upd_o = 1'b1;
                txd_o     = (idx_i == 8'd0) ? {4'hF, cfg_i.src_sel} : 8'hFF;
            end
            PH_LEN: begin
                crc_upd_o = 1'b1;
                txd_o     = (idx_i == 8'd0) ? LEN_FIELD[15:8] : LEN_FIELD[7:0];
            end
            PH_PAY: begin
                crc_upd_o = 1'b1;
                txd_o     = idx_i[0] ? cfg_i.pattern[7:0] : cfg_i.pattern[15:8];
            end
            PH_FCS: begin
                case (idx_i[1:0])
                    2'd0:    txd_o = fcs_word[7:0];
                    2'd1:    txd_o = fcs_word[15:8];
                    2'd2:    txd_o = fcs_word[23:16];
                    default: txd_o = fcs_word[31:24];
                endcase
            end
            default: tx_en_o = 1'b0;
        endcase
    end

    assign tx_er_o    = tx_en_o & cfg_i.txer_en;
    assign crc_init_o = (phase_i == PH_SFD);

endmodule

// File: rtl/test_frame_gen.sv
// Ethernet test frame generator, top level.
// Produces back-to-back fixed-length test frames on a byte interface.
// Configuration is taken when the generator leaves idle. Assumes the
// controls are synchronous to clk.
module test_frame_gen
    import efg_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int PAY_LEN = 46,
    parameter int GAP_LEN = 12,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [3:0]       dst_sel_i,
    input  logic [3:0]       src_sel_i,
    input  logic             txer_en_i,
    input  logic             bad_fcs_i,
    input  logic [15:0]      pattern_i,
    output logic [7:0]       txd_o,
    output logic             tx_en_o,
    output logic             tx_er_o,
    output logic [CNT_W-1:0] frame_cnt_o
);

    localparam int FRAME_LEN = PRE_LEN + 1 + 6 + 6 + 2 + PAY_LEN + 4;

    gen_cfg_t    cfg_in, cfg_q;
    phase_t      phase;
    logic [7:0]  idx;
    logic        start;
    logic        crc_init, crc_upd;
    logic [31:0] crc;

    assign cfg_in = '{dst_sel: dst_sel_i, src_sel: src_sel_i, txer_en: txer_en_i,
                      bad_fcs: bad_fcs_i, pattern: pattern_i};

    efg_sequencer #(
        .PRE_LEN (PRE_LEN),
        .PAY_LEN (PAY_LEN),
        .GAP_LEN (GAP_LEN),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .phase_o     (phase),
        .idx_o       (idx),
        .start_o     (start),
        .frame_cnt_o (frame_cnt_o)
    );

    efg_cfg_hold u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (start),
        .cfg_i     (cfg_in),
        .cfg_o     (cfg_q)
    );

    efg_crc_acc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (crc_init),
        .upd_i  (crc_upd),
        .byte_i (txd_o),
        .crc_o  (crc)
    );

    efg_byte_mux #(
        .PAY_LEN (PAY_LEN)
    ) u_mux (
        .phase_i    (phase),
        .idx_i      (idx),
        .cfg_i      (cfg_q),
        .crc_i      (crc),
        .txd_o      (txd_o),
        .tx_en_o    (tx_en_o),
        .tx_er_o    (tx_er_o),
        .crc_init_o (crc_init),
        .crc_upd_o  (crc_upd)
    );

endmodule

// File: rtl/efg_checker.sv
// Assertion checker for the test frame generator, bound to the top module.
// Frame length and gap length are measured with counters, not long $past chains.
module efg_checker
    import efg_pkg::*;
#(
    parameter int GAP_LEN   = 12,
    parameter int FRAME_LEN = 72,
    parameter int CNT_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       txd,
    input logic             tx_en,
    input logic             tx_er,
    input logic [CNT_W-1:0] frame_cnt,
    input gen_cfg_t         cfg
);

    logic [15:0] len_cnt;
    logic [15:0] gap_cnt;

    // Count consecutive enabled cycles and saturating idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_cnt <= '0;
            gap_cnt <= 16'(GAP_LEN);
        end else if (tx_en) begin
            len_cnt <= len_cnt + 1'b1;
            gap_cnt <= '0;
        end else begin
            len_cnt <= '0;
            gap_cnt <= (gap_cnt >= 16'(GAP_LEN)) ? gap_cnt : gap_cnt + 1'b1;
        end
    end

    p_preamble_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> txd == PRE_BYTE);

    p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> len_cnt == 16'(FRAME_LEN));

    p_txer_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> tx_er == $past(tx_er));

    p_txer_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_er |-> tx_en);

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> $stable(cfg));

    p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> gap_cnt >= 16'(GAP_LEN));

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> frame_cnt == $past(frame_cnt) + 1'b1);

    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(tx_en) |-> $stable(frame_cnt));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> txd == 8'h00);

endmodule

bind test_frame_gen efg_checker #(
    .GAP_LEN   (GAP_LEN),
    .FRAME_LEN (FRAME_LEN),
    .CNT_W     (CNT_W)
) u_efg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd       (txd_o),
    .tx_en     (tx_en_o),
    .tx_er     (tx_er_o),
    .frame_cnt (frame_cnt_o),
    .cfg       (cfg_q)
);

// File: tb/tb_test_frame_gen.sv
`timescale 1ns/1ps
module tb_test_frame_gen;

    typedef struct packed {
        logic [3:0]  dst;
        logic [3:0]  src;
        logic        txer;
        logic        bad;
        logic [15:0] pat;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 4'hF, 1'b0, 1'b0, 16'h0000},
        '{4'hA, 4'h5, 1'b1, 1'b0, 16'h1234},
        '{4'hF, 4'h0, 1'b0, 1'b1, 16'hA5C3},
        '{4'h3, 4'hC, 1'b1, 1'b1, 16'hFFFF},
        '{4'h7, 4'h7, 1'b0, 1'b0, 16'h00FF}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic [3:0]  dst_sel, src_sel;
    logic        txer_en, bad_fcs;
    logic [15:0] pattern;
    logic [7:0]  txd;
    logic        tx_en, tx_er;
    logic [15:0] frame_cnt;

    int checks = 0;
    int errors = 0;

    logic [7:0] fb [128];
    logic [7:0] ex [72];
    int         flen;
    bit         er_all, er_any;

    always #2.5 clk = ~clk;

    test_frame_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .dst_sel_i   (dst_sel),
        .src_sel_i   (src_sel),
        .txer_en_i   (txer_en),
        .bad_fcs_i   (bad_fcs),
        .pattern_i   (pattern),
        .txd_o       (txd),
        .tx_en_o     (tx_en),
        .tx_er_o     (tx_er),
        .frame_cnt_o (frame_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic apply_cfg(input vec_t v);
        dst_sel = v.dst;
        src_sel = v.src;
        txer_en = v.txer;
        bad_fcs = v.bad;
        pattern = v.pat;
    endtask

    // Expected 72-byte frame, computed bit-serially from the requirements
    task automatic build_expected(input vec_t v);
        logic [31:0] c;
        logic        b;
        for (int k = 0; k < 7; k++) ex[k] = 8'h55;
        ex[7] = 8'hD5;
        for (int k = 0; k < 6; k++) begin
            ex[8 + k]  = (k == 0) ? {4'hF, v.dst} : 8'hFF;
            ex[14 + k] = (k == 0) ? {4'hF, v.src} : 8'hFF;
        end
        ex[20] = 8'h00;
        ex[21] = 8'h2E;
        for (int k = 0; k < 46; k++) ex[22 + k] = (k % 2 == 0) ? v.pat[15:8] : v.pat[7:0];
        c = 32'hFFFFFFFF;
        for (int k = 8; k < 68; k++) begin
            for (int j = 0; j < 8; j++) begin
                b = c[0] ^ ex[k][j];
                c = {1'b0, c[31:1]};
                if (b) c = c ^ 32'hEDB88320;
            end
        end
        if (!v.bad) c = ~c;
        for (int k = 0; k < 4; k++) ex[68 + k] = c[8*k +: 8];
    endtask

    // Collect one frame at falling edges; may drop or raise run at given byte indices
    task automatic capture_frame(input int stop_at, input int resume_at);
        int t;
        t = 0;
        flen = 0;
        er_all = 1'b1;
        er_any = 1'b0;
        while (!tx_en && t < 400) begin
            @(negedge clk);
            t++;
        end
        while (tx_en && flen < 128) begin
            fb[flen] = txd;
            er_all &= tx_er;
            er_any |= tx_er;
            flen++;
            if (flen == stop_at) run = 1'b0;
            if (flen == resume_at) run = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic measure_idle(input int lim, output int g);
        g = 0;
        while (!tx_en && g < lim) begin
            if (txd != 8'h00) begin
                chk(1'b0, "R11", "txd while idle", txd, 0);
            end
            g++;
            @(negedge clk);
        end
    endtask

    task automatic cmp_range(input int lo, input int hi, input string req, input string what);
        int  bad_at;
        bad_at = -1;
        for (int k = hi; k >= lo; k--) if (fb[k] !== ex[k]) bad_at = k;
        if (bad_at < 0) chk(1'b1, req, what, 0, 0);
        else chk(1'b0, req, $sformatf("%s byte %0d", what, bad_at), fb[bad_at], ex[bad_at]);
    endtask

    task automatic check_frame(input vec_t v);
        build_expected(v);
        chk(flen == 72, "R2", "frame length", flen, 72);
        if (flen == 72) begin
            cmp_range(0, 7, "R2", "preamble/SFD");
            cmp_range(20, 21, "R2", "length field");
            cmp_range(8, 19, "R3", "addresses");
            cmp_range(22, 67, "R5", "payload");
            cmp_range(68, 71, "R6", "FCS");
        end
        chk(er_all == v.txer && er_any == v.txer, "R4", "tx_er over frame", {er_any, er_all}, {v.txer, v.txer});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int g;
        int base;
        rst_n = 1'b0;
        run = 1'b0;
        apply_cfg(VECS[1]);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(txd == 8'h00 && !tx_en && !tx_er, "R1", "outputs after reset", {txd, tx_en, tx_er}, 0);
        chk(frame_cnt == 16'd0, "R1", "frame count after reset", frame_cnt, 0);
        // R11: idle stays quiet with run low
        measure_idle(20, g);
        chk(g == 20, "R11", "idle cycles with run low", g, 20);

        // Vector table: one frame each, run dropped mid-frame (R9)
        for (int i = 0; i < NV; i++) begin
            apply_cfg(VECS[i]);
            run = 1'b1;
            capture_frame(30, -1);
            check_frame(VECS[i]);
            measure_idle(40, g);
            chk(g == 40, "R9", "no frame after stop", g, 40);
            chk(frame_cnt == 16'(i + 1), "R10", "frame count per frame", frame_cnt, i + 1);
        end

        // R8: back-to-back frames with exact gap
        base = frame_cnt;
        apply_cfg(VECS[2]);
        run = 1'b1;
        capture_frame(-1, -1);
        check_frame(VECS[2]);
        measure_idle(40, g);
        chk(g == 12, "R8", "gap between frames", g, 12);
        capture_frame(-1, -1);
        check_frame(VECS[2]);
        measure_idle(40, g);
        chk(g == 12, "R8", "second gap", g, 12);
        capture_frame(10, -1);
        chk(flen == 72, "R9", "frame finished after stop", flen, 72);
        measure_idle(40, g);
        chk(frame_cnt == 16'(base + 3), "R10", "count after three frames", frame_cnt, base + 3);

        // R7: changes and a brief run drop while running are ignored
        apply_cfg(VECS[1]);
        run = 1'b1;
        @(negedge clk);
        apply_cfg(VECS[3]);
        capture_frame(20, 21);
        check_frame(VECS[1]);
        measure_idle(40, g);
        chk(g == 12, "R7", "run pulse did not stop stream", g, 12);
        capture_frame(10, -1);
        build_expected(VECS[1]);
        cmp_range(8, 19, "R7", "addresses held after change");
        cmp_range(68, 71, "R7", "FCS mode held after change");
        chk(er_any == VECS[1].txer, "R7", "tx_er mode held", er_any, VECS[1].txer);
        measure_idle(40, g);
        // R7: fresh start takes the new settings
        run = 1'b1;
        capture_frame(5, -1);
        check_frame(VECS[3]);
        measure_idle(40, g);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule